// File: doc/BRIEF.md
# Three-Wire Serial Configuration Register Bank

This block is a write-only configuration port for a radio front end. A host shifts 16-bit words in over three wires: a serial clock, a data line and an active-low select. While select is low, each rising serial clock edge appends one data bit. The bits arrive most significant first. When select returns high, the word is decoded and the register it addresses is updated. Each word carries 14 data bits followed by a 2-bit register address.

Three registers exist:
- a synthesizer setup register,
- a channel register, which is split into a 10-bit integer part and a 4-bit fraction part,
- a test-mode register.

A write that lands in the channel register also raises a one-cycle strobe. This strobe tells the downstream filter tuning logic to start a new calibration.

The three serial lines are asynchronous to the system clock. They pass through two-flop synchronisers, and their edges are detected in the system clock domain. The system clock must run at least four times faster than the serial clock.

The data itself is not checked. However, a word cut short (fewer than 16 bits) is dropped and reported, and a word addressed to the unused address 3 is also dropped. In both cases the outcome is defined.

Top module: `serial_cfg_bank`

## Requirements
- R1: After reset every register field is zero and both strobes (`cal_start`, `short_word`) are low.
- R2: Serial clock edges and data values seen while `ser_sel_n` is high are ignored; they neither shift bits in nor count toward the 16 bits of the next word.
- R3: A word is sent MSB first; on the rise of `ser_sel_n` its bits 15:2 are the data and bits 1:0 the address; address 0 loads the data into `pll_word`.
- R4: Address 1 loads the channel register; word bits 15:6 appear on `chan_int` and word bits 5:2 on `chan_frac`.
- R5: Address 2 loads the data into `test_word`.
- R6: Address 3 is discarded and changes no register and raises no strobe.
- R7: `cal_start` pulses high for exactly one system clock for each complete write to address 1, and never for writes to other addresses.
- R8: If fewer than 16 bits were shifted in before `ser_sel_n` rises, `short_word` pulses for one cycle, no register changes and `cal_start` stays low.
- R9: If more than 16 bits are shifted in, only the last 16 form the word.
- R10: Register outputs and strobes settle within 4 system clocks after the rise of `ser_sel_n` and stay unchanged until the next commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_dat | input | 1 | Serial data line, asynchronous |
| ser_sel_n | input | 1 | Active-low word select; rising edge commits |
| pll_word | output | 14 | Synthesizer setup register (address 0) |
| chan_int | output | 10 | Channel register integer part (address 1) |
| chan_frac | output | 4 | Channel register fraction part (address 1) |
| test_word | output | 14 | Test-mode register (address 2) |
| cal_start | output | 1 | One-cycle pulse on each channel register write |
| short_word | output | 1 | One-cycle pulse when a word under 16 bits is dropped |

## Verification
The assertions rely on these input conditions:
- The serial clock runs no faster than a quarter of the system clock.
- Data is steady around each serial clock rise.
- The select line never changes in the same synchronised sample as a serial clock rise.

Under these conditions each rise yields exactly one shift, and select edges never coincide with a shift. The stimulus holds every serial phase for four system clocks. It changes data only while the serial clock is low. It leaves four system clocks between the last serial clock fall and the rise of select. It also waits before sampling, so every commit has settled.

// File: rtl/cfgbus_pkg.sv
package cfgbus_pkg;
    localparam int WORD_W    = 16;
    localparam int ADDR_W    = 2;
    localparam int DATA_W    = WORD_W - ADDR_W;
    localparam int NREG      = 3;
    localparam int FRAC_W    = 4;
    localparam int INT_W     = DATA_W - FRAC_W;
    localparam int CNT_W     = $clog2(WORD_W + 1);
    localparam int SYNC_N    = 2;
    localparam int ADDR_PLL  = 0;
    localparam int ADDR_CHAN = 1;
    localparam int ADDR_TEST = 2;

    typedef logic [DATA_W-1:0] field_t;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/cfgbus_sync.sv
module cfgbus_sync #(
    parameter int            W       = 3,
    parameter int            STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= {STAGES{RST_VAL}};
        else        stg_q <= stg_d;
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cfgbus_shift.sv
module cfgbus_shift
    import cfgbus_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sclk_i,
    input  logic  sdat_i,
    input  logic  sen_i,     // synchronised select level, high = idle
    output logic  commit_o,
    output logic  full_o,
    output word_t word_o
);
    typedef struct packed {
        logic             sclk_prev;
        logic             sen_prev;
        word_t            sh;
        logic [CNT_W-1:0] cnt;
        logic             commit;
        logic             full;
        word_t            word;
    } shift_st_t;

    shift_st_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.commit    = 1'b0;
        st_d.sclk_prev = sclk_i;
        st_d.sen_prev  = sen_i;
        if (sclk_i && !st_q.sclk_prev && !sen_i) begin
            st_d.sh = {st_q.sh[WORD_W-2:0], sdat_i};
            if (st_q.cnt != CNT_W'(WORD_W)) st_d.cnt = st_q.cnt + 1'b1;
        end
        if (sen_i && !st_q.sen_prev) begin
            st_d.commit = 1'b1;
            st_d.full   = (st_q.cnt == CNT_W'(WORD_W));
            st_d.word   = st_q.sh;
            st_d.cnt    = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.sen_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign commit_o = st_q.commit;
    assign full_o   = st_q.full;
    assign word_o   = st_q.word;

    // R9: the bit counter saturates at one word
    p_cnt_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(WORD_W));
    // R2: nothing shifts while select is idle
    p_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sen_i |=> $stable(st_q.sh));
    // R3: commit is a single-cycle event
    p_commit_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.commit |=> !st_q.commit);
endmodule

// File: rtl/cfgbus_regs.sv
module cfgbus_regs
    import cfgbus_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         commit_i,
    input  logic                         full_i,
    input  word_t                        word_i,
    output logic [NREG-1:0][DATA_W-1:0]  regs_o,
    output logic                         cal_o,
    output logic                         short_o
);
    typedef struct packed {
        logic [NREG-1:0][DATA_W-1:0] regs;
        logic                        cal;
        logic                        short_w;
    } regs_st_t;

    regs_st_t           st_d, st_q;
    logic [ADDR_W-1:0]  addr;
    field_t             data;

    assign addr = word_i[ADDR_W-1:0];
    assign data = word_i[WORD_W-1:ADDR_W];

    always_comb begin
        st_d         = st_q;
        st_d.cal     = 1'b0;
        st_d.short_w = 1'b0;
        if (commit_i) begin
            if (!full_i) begin
                st_d.short_w = 1'b1;
            end else begin
                for (int r = 0; r < NREG; r++) begin
                    if (addr == ADDR_W'(r)) st_d.regs[r] = data;
                end
                st_d.cal = (addr == ADDR_W'(ADDR_CHAN));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign regs_o  = st_q.regs;
    assign cal_o   = st_q.cal;
    assign short_o = st_q.short_w;

    // R7: calibration strobe never lasts longer than one cycle
    p_cal_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cal |=> !st_q.cal);
    // R10: registers hold between commits
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(st_q.regs));
    // R8: a short word leaves every register untouched
    p_short_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && !full_i) |=> ($stable(st_q.regs) && !st_q.cal));
    // R6: the unused address changes nothing
    p_unused_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && addr == ADDR_W'(NREG)) |=> ($stable(st_q.regs) && !st_q.cal));
endmodule

// File: rtl/serial_cfg_bank.sv
module serial_cfg_bank
    import cfgbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              ser_sel_n,
    output logic [13:0]       pll_word,
    output logic [9:0]        chan_int,
    output logic [3:0]        chan_frac,
    output logic [13:0]       test_word,
    output logic              cal_start,
    output logic              short_word
);
    logic [2:0]                   pins_s;
    logic                         commit, full;
    word_t                        word;
    logic [NREG-1:0][DATA_W-1:0]  regs;

    cfgbus_sync #(.W(3), .STAGES(SYNC_N), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({ser_sel_n, ser_dat, ser_clk}),
        .q_o   (pins_s)
    );

    cfgbus_shift u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_i   (pins_s[0]),
        .sdat_i   (pins_s[1]),
        .sen_i    (pins_s[2]),
        .commit_o (commit),
        .full_o   (full),
        .word_o   (word)
    );

    cfgbus_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit),
        .full_i   (full),
        .word_i   (word),
        .regs_o   (regs),
        .cal_o    (cal_start),
        .short_o  (short_word)
    );

    assign pll_word  = regs[ADDR_PLL];
    assign chan_int  = regs[ADDR_CHAN][DATA_W-1:FRAC_W];
    assign chan_frac = regs[ADDR_CHAN][FRAC_W-1:0];
    assign test_word = regs[ADDR_TEST];
endmodule

// File: tb/serial_cfg_bank_test.sv
module serial_cfg_bank_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_sel_n = 1'b1;
    logic [13:0] pll_word, test_word;
    logic [9:0]  chan_int;
    logic [3:0]  chan_frac;
    logic        cal_start, short_word;

    always #5 clk = ~clk;

    serial_cfg_bank uut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_sel_n(ser_sel_n), .pll_word(pll_word), .chan_int(chan_int),
        .chan_frac(chan_frac), .test_word(test_word), .cal_start(cal_start),
        .short_word(short_word)
    );

    typedef struct {
        logic [13:0] pll;
        logic [13:0] chan;
        logic [13:0] test;
        int          cal_n;
        int          short_n;
        string       req;
    } exp_t;

    exp_t        sb_q[$];
    event        chk_ev;
    int          n_chk = 0, n_bad = 0;
    int          cal_seen = 0, short_seen = 0;
    logic [13:0] m_pll = '0, m_chan = '0, m_test = '0;
    int          m_cal = 0, m_short = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // monitor: counts strobe cycles, compares on each scoreboard event
    always @(negedge clk) begin
        if (rst_n && cal_start)  cal_seen++;
        if (rst_n && short_word) short_seen++;
    end

    initial begin
        forever begin
            @(chk_ev);
            if (sb_q.size() != 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check({e.req, " pll_word"},   32'(pll_word),  32'(e.pll));
                check({e.req, " chan_int"},   32'(chan_int),  32'(e.chan[13:4]));
                check({e.req, " chan_frac"},  32'(chan_frac), 32'(e.chan[3:0]));
                check({e.req, " test_word"},  32'(test_word), 32'(e.test));
                check({e.req, " cal pulses"}, 32'(cal_seen),  32'(e.cal_n));
                check({e.req, " short pulses"}, 32'(short_seen), 32'(e.short_n));
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bit(input logic b);
        ser_dat = b;
        wait_clk(4);
        ser_clk = 1'b1;
        wait_clk(4);
        ser_clk = 1'b0;
    endtask

    // driver: shift n bits MSB first, update model, push expectation
    task automatic send(input logic [31:0] bits, input int n, input string req);
        logic [15:0] w;
        ser_sel_n = 1'b0;
        wait_clk(4);
        for (int i = n - 1; i >= 0; i--) shift_bit(bits[i]);
        wait_clk(4);
        ser_sel_n = 1'b1;
        w = bits[15:0];
        if (n < 16) m_short++;
        else begin
            case (w[1:0])
                2'd0: m_pll  = w[15:2];
                2'd1: begin m_chan = w[15:2]; m_cal++; end
                2'd2: m_test = w[15:2];
                default: ;
            endcase
        end
        sb_q.push_back('{m_pll, m_chan, m_test, m_cal, m_short, req});
        wait_clk(12);
        -> chk_ev;
        wait_clk(2);
    endtask

    initial begin
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(2);
        // R1 reset state
        check("R1 pll_word",  32'(pll_word),  0);
        check("R1 chan_int",  32'(chan_int),  0);
        check("R1 chan_frac", 32'(chan_frac), 0);
        check("R1 test_word", 32'(test_word), 0);
        check("R1 cal_start", 32'(cal_start), 0);
        check("R1 short_word", 32'(short_word), 0);

        send({14'h1234, 2'd0}, 16, "R3 pll write");
        send({10'd229, 4'd0, 2'd1}, 16, "R4 R7 chan write");
        send({14'h3FFF, 2'd2}, 16, "R5 test write");
        send({14'h0AAA, 2'd3}, 16, "R6 unused address");
        send({10'd77, 4'd2, 2'd1}, 15, "R8 short word");

        // R2: toggles while select idle must not count toward the next word
        for (int k = 0; k < 5; k++) shift_bit(k[0]);
        send({14'h2222, 2'd0}, 11, "R2 ignored while idle");

        // R9: 20 bits, the leading 4 are flushed out
        send({4'hF, 10'd5, 4'd8, 2'd1}, 20, "R9 R4 long word");
        send({10'd1023, 4'd3, 2'd1}, 16, "R7 second chan write");
        send({14'h0000, 2'd0}, 16, "R3 R10 pll clear");
        send({14'h1555, 2'd2}, 16, "R5 R7 test no cal");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule